// File: doc/BRIEF.md
# Ring-Buffer Command Fetch Engine

This block reads commands for a graphics coprocessor out of a ring held in local memory. Software places 16-bit command words into the ring and then moves a write pointer forward through a small 16-bit register interface. The engine reads one word at a time from its read pointer until the read pointer equals the write pointer. It wraps the read pointer at the configured ring length and hands each word to a downstream command consumer over a valid/ready stream.

Both pointers are even byte offsets into the ring. Each pointer is split into a low 16-bit half and a high half. The ring length is programmed in 1 KiB units minus one. A status word reports whether the reader is idle and whether the whole pipeline is idle, together with the busy flags of the 2D, 3D and ISP engines. A pair of zero words is a no-op. The engine passes it through like any other word, and the consumer drops it.

Top module: `cmdq_fetch`

## Requirements
- R1: After reset, the base, length, read pointer and write pointer registers all read 0. No memory request or output word is produced. With all engines idle, the status register reads 0x0007.
- R2: Register readback at these byte offsets:
  - base low 0x00 returns all 16 bits.
  - base high 0x02 keeps only bits [6:0].
  - length 0x04 keeps LEN_W bits.
  - flip 0x0a keeps 16 bits.
  - control 0x0c keeps only bit 12 (flip mode), bits [11:8] (interrupt mode) and bits [7:4] (threshold); all other bits read 0.
- R3: A write to a pointer high half (write pointer 0x08, read pointer 0x10) is only staged. The readback value and the fetch logic do not change until the matching low half (0x06 or 0x0e) is written.
- R4: A write to the low half commits a new write pointer equal to {staged high, written low} ANDed with the wrap mask ((length+1)*1024-1), with bit 0 forced to 0.
- R5: The engine issues memory reads only while the read pointer differs from the write pointer. When the two pointers are equal, no request is made.
- R6: Each memory read presents the address base+read pointer, where base = {base high[6:0], base low}. At most one read is outstanding, and the word is taken on the response strobe.
- R7: Words leave in ring order. An offered word and its data stay stable until accepted. The read pointer advances by 2 only on acceptance, and its readback shows the advanced value.
- R8: When an accepted step would take the read pointer past the wrap mask, the read pointer becomes 0. This holds for ring sizes that are not powers of two.
- R9: Status register 0x12:
  - bits [1:0] read 11 when the reader is idle (pointers equal, no word in flight) and 00 otherwise;
  - bit 2 is set when the reader is idle and no engine is busy;
  - bits 4, 5 and 8 mirror the 2D, 3D and ISP busy inputs;
  - all other bits read 0.
- R10: A read pointer commit loads the read pointer only while the reader is idle. A commit arriving while a word is being fetched or offered is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register byte offset |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data for reg_addr_i (combinational) |
| mem_req_o | output | 1 | One-cycle memory read request |
| mem_addr_o | output | 16+BASE_HI_W | Byte address of the requested word |
| mem_rvalid_i | input | 1 | Memory response strobe |
| mem_rdata_i | input | 16 | Memory response word |
| cmd_valid_o | output | 1 | Command word offered |
| cmd_ready_i | input | 1 | Consumer accepts the offered word |
| cmd_data_o | output | 16 | Command word |
| eng2d_busy_i | input | 1 | 2D engine busy |
| eng3d_busy_i | input | 1 | 3D engine busy |
| isp_busy_i | input | 1 | ISP engine busy |

## Verification
The bench builds the block with the defaults LEN_W=7 and BASE_HI_W=7. This gives a ring of up to 128 KiB with a 17-bit pointer, so the high pointer halves carry a live bit. The bench can then wrap across bit 16 by loading the read pointer near the top of the largest ring.

A length of 2 gives a 3 KiB ring, whose mask is not a power of two minus one. That case exercises the compare-based wrap. A length of 0 covers the masking of committed write pointers. Varying the memory latency and stalling the consumer brings the hold rule and the ignored read pointer commit within reach.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
  localparam logic [4:0] RA_BASE_LO = 5'h00;
  localparam logic [4:0] RA_BASE_HI = 5'h02;
  localparam logic [4:0] RA_LEN     = 5'h04;
  localparam logic [4:0] RA_WP_LO   = 5'h06;
  localparam logic [4:0] RA_WP_HI   = 5'h08;
  localparam logic [4:0] RA_FLIP    = 5'h0a;
  localparam logic [4:0] RA_CTRL    = 5'h0c;
  localparam logic [4:0] RA_RP_LO   = 5'h0e;
  localparam logic [4:0] RA_RP_HI   = 5'h10;
  localparam logic [4:0] RA_STATUS  = 5'h12;

  localparam int CTRL_FLIP_BIT = 12;
  localparam int CTRL_IRQ_LSB  = 8;
  localparam int CTRL_THR_LSB  = 4;

  localparam int ST_ALL_IDLE = 2;
  localparam int ST_2D_BUSY  = 4;
  localparam int ST_3D_BUSY  = 5;
  localparam int ST_ISP_BUSY = 8;

  typedef enum logic [1:0] {
    FS_IDLE,
    FS_REQ,
    FS_WAIT,
    FS_OUT
  } fetch_state_e;
endpackage

// File: rtl/cmdq_regs.sv
module cmdq_regs
  import cmdq_pkg::*;
#(
  parameter int LEN_W     = 7,
  parameter int BASE_HI_W = 7,
  parameter int PTR_W     = LEN_W + 10,
  parameter int ADDR_W    = 16 + BASE_HI_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [4:0]        reg_addr_i,
  input  logic [15:0]       reg_wdata_i,
  output logic [15:0]       reg_rdata_o,
  input  logic [PTR_W-1:0]  rd_ptr_i,
  input  logic [15:0]       status_i,
  output logic [ADDR_W-1:0] base_o,
  output logic [PTR_W-1:0]  mask_o,
  output logic [PTR_W-1:0]  wr_ptr_o,
  output logic              rd_load_o,
  output logic [PTR_W-1:0]  rd_load_val_o
);
  localparam int PHI_W = PTR_W - 16;

  logic [15:0]          base_lo_q;
  logic [BASE_HI_W-1:0] base_hi_q;
  logic [LEN_W-1:0]     len_q;
  logic [15:0]          flip_q;
  logic                 c_flip_q;
  logic [3:0]           c_irq_q;
  logic [3:0]           c_thr_q;
  logic [PHI_W-1:0]     wp_stage_q;
  logic [PHI_W-1:0]     rp_stage_q;
  logic [PTR_W-1:0]     wr_ptr_q;
  logic [PTR_W-1:0]     wp_commit;

  logic wr_base_lo, wr_base_hi, wr_len, wr_flip, wr_ctrl;
  logic wr_wp_lo, wr_wp_hi, wr_rp_lo, wr_rp_hi;

  assign wr_base_lo = reg_wr_i && (reg_addr_i == RA_BASE_LO);
  assign wr_base_hi = reg_wr_i && (reg_addr_i == RA_BASE_HI);
  assign wr_len     = reg_wr_i && (reg_addr_i == RA_LEN);
  assign wr_flip    = reg_wr_i && (reg_addr_i == RA_FLIP);
  assign wr_ctrl    = reg_wr_i && (reg_addr_i == RA_CTRL);
  assign wr_wp_lo   = reg_wr_i && (reg_addr_i == RA_WP_LO);
  assign wr_wp_hi   = reg_wr_i && (reg_addr_i == RA_WP_HI);
  assign wr_rp_lo   = reg_wr_i && (reg_addr_i == RA_RP_LO);
  assign wr_rp_hi   = reg_wr_i && (reg_addr_i == RA_RP_HI);

  // (len+1)*1024-1 == {len, ten ones}
  assign mask_o = {len_q, 10'h3ff};
  assign base_o = {base_hi_q, base_lo_q};

  assign wp_commit     = ({wp_stage_q, reg_wdata_i} & mask_o) & ~PTR_W'(1);
  assign rd_load_val_o = ({rp_stage_q, reg_wdata_i} & mask_o) & ~PTR_W'(1);
  assign rd_load_o     = wr_rp_lo;
  assign wr_ptr_o      = wr_ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_lo_q  <= '0;
      base_hi_q  <= '0;
      len_q      <= '0;
      flip_q     <= '0;
      c_flip_q   <= 1'b0;
      c_irq_q    <= '0;
      c_thr_q    <= '0;
      wp_stage_q <= '0;
      rp_stage_q <= '0;
      wr_ptr_q   <= '0;
    end else begin
      if (wr_base_lo) base_lo_q <= reg_wdata_i;
      if (wr_base_hi) base_hi_q <= reg_wdata_i[BASE_HI_W-1:0];
      if (wr_len)     len_q     <= reg_wdata_i[LEN_W-1:0];
      if (wr_flip)    flip_q    <= reg_wdata_i;
      if (wr_ctrl) begin
        c_flip_q <= reg_wdata_i[CTRL_FLIP_BIT];
        c_irq_q  <= reg_wdata_i[CTRL_IRQ_LSB +: 4];
        c_thr_q  <= reg_wdata_i[CTRL_THR_LSB +: 4];
      end
      if (wr_wp_hi) wp_stage_q <= reg_wdata_i[PHI_W-1:0];
      if (wr_rp_hi) rp_stage_q <= reg_wdata_i[PHI_W-1:0];
      if (wr_wp_lo) wr_ptr_q   <= wp_commit;
    end
  end

  always_comb begin
    unique case (reg_addr_i)
      RA_BASE_LO: reg_rdata_o = base_lo_q;
      RA_BASE_HI: reg_rdata_o = 16'(base_hi_q);
      RA_LEN:     reg_rdata_o = 16'(len_q);
      RA_WP_LO:   reg_rdata_o = wr_ptr_q[15:0];
      RA_WP_HI:   reg_rdata_o = 16'(wr_ptr_q[PTR_W-1:16]);
      RA_FLIP:    reg_rdata_o = flip_q;
      RA_CTRL:    reg_rdata_o = {3'b000, c_flip_q, c_irq_q, c_thr_q, 4'b0000};
      RA_RP_LO:   reg_rdata_o = rd_ptr_i[15:0];
      RA_RP_HI:   reg_rdata_o = 16'(rd_ptr_i[PTR_W-1:16]);
      RA_STATUS:  reg_rdata_o = status_i;
      default:    reg_rdata_o = '0;
    endcase
  end

  // R3
  wp_stage_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_wp_hi && !wr_wp_lo |=> $stable(wr_ptr_o));

  // R4
  wp_even_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_wp_lo |=> !wr_ptr_o[0]);
endmodule

// File: rtl/cmdq_fetch_core.sv
module cmdq_fetch_core
  import cmdq_pkg::*;
#(
  parameter int PTR_W  = 17,
  parameter int ADDR_W = 23
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [PTR_W-1:0]  mask_i,
  input  logic [PTR_W-1:0]  wr_ptr_i,
  input  logic              rd_load_i,
  input  logic [PTR_W-1:0]  rd_load_val_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [15:0]       mem_rdata_i,
  output logic              cmd_valid_o,
  input  logic              cmd_ready_i,
  output logic [15:0]       cmd_data_o,
  output logic [PTR_W-1:0]  rd_ptr_o,
  output logic              reader_idle_o
);
  fetch_state_e     state_q;
  logic [PTR_W-1:0] rd_ptr_q;
  logic [15:0]      data_q;
  logic [PTR_W:0]   inc;
  logic [PTR_W-1:0] rd_next;
  logic             have_work;

  assign inc       = {1'b0, rd_ptr_q} + (PTR_W+1)'(2);
  assign rd_next   = (inc > {1'b0, mask_i}) ? '0 : inc[PTR_W-1:0];
  assign have_work = (rd_ptr_q != wr_ptr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= FS_IDLE;
      rd_ptr_q <= '0;
      data_q   <= '0;
    end else begin
      unique case (state_q)
        FS_IDLE: begin
          if (rd_load_i)      rd_ptr_q <= rd_load_val_i;
          else if (have_work) state_q  <= FS_REQ;
        end
        FS_REQ: state_q <= FS_WAIT;
        FS_WAIT: begin
          if (mem_rvalid_i) begin
            data_q  <= mem_rdata_i;
            state_q <= FS_OUT;
          end
        end
        FS_OUT: begin
          if (cmd_ready_i) begin
            rd_ptr_q <= rd_next;
            state_q  <= (rd_next != wr_ptr_i) ? FS_REQ : FS_IDLE;
          end
        end
        default: state_q <= FS_IDLE;
      endcase
    end
  end

  assign mem_req_o     = (state_q == FS_REQ);
  assign mem_addr_o    = base_i + ADDR_W'(rd_ptr_q);
  assign cmd_valid_o   = (state_q == FS_OUT);
  assign cmd_data_o    = data_q;
  assign rd_ptr_o      = rd_ptr_q;
  assign reader_idle_o = (state_q == FS_IDLE) && !have_work;

  // R6
  one_outstanding_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);

  // R7
  hold_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_data_o));

  // R8
  rd_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && cmd_ready_i |=>
      (rd_ptr_q == $past(rd_ptr_q) + PTR_W'(2)) || (rd_ptr_q == '0));

  // R10
  rd_load_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_load_i && (state_q == FS_REQ || state_q == FS_WAIT) |=> $stable(rd_ptr_q));
endmodule

// File: rtl/cmdq_status.sv
module cmdq_status
  import cmdq_pkg::*;
(
  input  logic        reader_idle_i,
  input  logic        eng2d_busy_i,
  input  logic        eng3d_busy_i,
  input  logic        isp_busy_i,
  output logic [15:0] status_o
);
  always_comb begin
    status_o              = '0;
    status_o[1:0]         = {2{reader_idle_i}};
    status_o[ST_ALL_IDLE] = reader_idle_i && !(eng2d_busy_i || eng3d_busy_i || isp_busy_i);
    status_o[ST_2D_BUSY]  = eng2d_busy_i;
    status_o[ST_3D_BUSY]  = eng3d_busy_i;
    status_o[ST_ISP_BUSY] = isp_busy_i;
  end
endmodule

// File: rtl/cmdq_fetch.sv
module cmdq_fetch
  import cmdq_pkg::*;
#(
  parameter int LEN_W     = 7,
  parameter int BASE_HI_W = 7
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  reg_wr_i,
  input  logic [4:0]            reg_addr_i,
  input  logic [15:0]           reg_wdata_i,
  output logic [15:0]           reg_rdata_o,
  output logic                  mem_req_o,
  output logic [16+BASE_HI_W-1:0] mem_addr_o,
  input  logic                  mem_rvalid_i,
  input  logic [15:0]           mem_rdata_i,
  output logic                  cmd_valid_o,
  input  logic                  cmd_ready_i,
  output logic [15:0]           cmd_data_o,
  input  logic                  eng2d_busy_i,
  input  logic                  eng3d_busy_i,
  input  logic                  isp_busy_i
);
  localparam int PTR_W  = LEN_W + 10;
  localparam int ADDR_W = 16 + BASE_HI_W;

  logic [ADDR_W-1:0] base;
  logic [PTR_W-1:0]  mask, wr_ptr, rd_ptr, rd_load_val;
  logic              rd_load, reader_idle;
  logic [15:0]       status;

  cmdq_regs #(
    .LEN_W(LEN_W), .BASE_HI_W(BASE_HI_W), .PTR_W(PTR_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk_i, .rst_ni, .reg_wr_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .rd_ptr_i(rd_ptr), .status_i(status), .base_o(base), .mask_o(mask),
    .wr_ptr_o(wr_ptr), .rd_load_o(rd_load), .rd_load_val_o(rd_load_val)
  );

  cmdq_fetch_core #(.PTR_W(PTR_W), .ADDR_W(ADDR_W)) u_core (
    .clk_i, .rst_ni, .base_i(base), .mask_i(mask), .wr_ptr_i(wr_ptr),
    .rd_load_i(rd_load), .rd_load_val_i(rd_load_val),
    .mem_req_o, .mem_addr_o, .mem_rvalid_i, .mem_rdata_i,
    .cmd_valid_o, .cmd_ready_i, .cmd_data_o,
    .rd_ptr_o(rd_ptr), .reader_idle_o(reader_idle)
  );

  cmdq_status u_status (
    .reader_idle_i(reader_idle), .eng2d_busy_i, .eng3d_busy_i, .isp_busy_i,
    .status_o(status)
  );

  // R9
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status[1:0] == 2'b11 |-> !mem_req_o && !cmd_valid_o);
endmodule

// File: tb/sim_cmdq_fetch.sv
module sim_cmdq_fetch;
  localparam int CLK_PERIOD = 10;
  localparam int LEN_W = 7;
  localparam int BASE_HI_W = 7;
  localparam int PTR_W = LEN_W + 10;
  localparam int ADDR_W = 16 + BASE_HI_W;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic reg_wr_i = 1'b0;
  logic [4:0] reg_addr_i = '0;
  logic [15:0] reg_wdata_i = '0;
  logic [15:0] reg_rdata_o;
  logic mem_req_o;
  logic [ADDR_W-1:0] mem_addr_o;
  logic mem_rvalid_i = 1'b0;
  logic [15:0] mem_rdata_i = '0;
  logic cmd_valid_o;
  logic cmd_ready_i = 1'b0;
  logic [15:0] cmd_data_o;
  logic eng2d_busy_i = 1'b0, eng3d_busy_i = 1'b0, isp_busy_i = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmdq_fetch #(.LEN_W(LEN_W), .BASE_HI_W(BASE_HI_W)) u0 (.clk_i(clk), .*);

  int n_tests = 0, n_fail = 0;
  int req_cnt = 0;
  int rdy_mode = 0;
  bit done = 0;
  logic [15:0] exp_q[$];
  logic [ADDR_W-1:0] m_base = '0;
  logic [PTR_W-1:0]  m_mask = 17'h3ff;

  function automatic logic [15:0] fdat(logic [ADDR_W-1:0] a);
    return a[16:1] ^ 16'h3c5a ^ {9'h0, a[22:16]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic push_span(input logic [PTR_W-1:0] from, input logic [PTR_W-1:0] upto);
    logic [PTR_W-1:0] p = from;
    while (p != upto) begin
      exp_q.push_back(fdat(m_base + ADDR_W'(p)));
      p = ({1'b0, p} + 18'd2 > {1'b0, m_mask}) ? '0 : p + PTR_W'(2);
    end
  endtask

  task automatic wreg(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk);
    reg_wr_i = 1'b0;
  endtask

  task automatic rreg(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  task automatic wait_idle(input string tag);
    bit ok = 0;
    for (int i = 0; i < 40000; i++) begin
      @(negedge clk);
      reg_addr_i = 5'h12;
      #1;
      if (reg_rdata_o[0] && exp_q.size() == 0 && !cmd_valid_o) begin
        ok = 1;
        break;
      end
    end
    chk({tag, " drained"}, 32'(ok), 32'd1);
  endtask

  // memory model: variable latency, data derived from address
  int pend = 0, lat_cnt = 0, lat_sel = 0;
  logic [ADDR_W-1:0] paddr;
  always @(negedge clk) begin
    mem_rvalid_i = 1'b0;
    if (pend != 0) begin
      if (lat_cnt == 0) begin
        mem_rvalid_i = 1'b1;
        mem_rdata_i = fdat(paddr);
        pend = 0;
      end else lat_cnt--;
    end
    if (mem_req_o) begin
      req_cnt++;
      pend = 1;
      paddr = mem_addr_o;
      lat_cnt = lat_sel % 4;
      lat_sel++;
    end
  end

  // consumer and scoreboard monitor
  int cyc = 0;
  bit prev_stall = 0;
  logic [15:0] prev_data;
  always @(negedge clk) begin
    logic rdy;
    cyc++;
    rdy = (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? (cyc % 3 == 0) : 1'b0;
    cmd_ready_i = rdy;
    if (rst_ni && cmd_valid_o) begin
      if (prev_stall) chk("R7 hold", 32'(cmd_data_o), 32'(prev_data));
      if (rdy) begin
        if (exp_q.size() == 0) chk("R7 unexpected word", 32'(cmd_data_o), 32'hffffffff);
        else chk("R7 order", 32'(cmd_data_o), 32'(exp_q.pop_front()));
      end
    end
    prev_stall = cmd_valid_o && !rdy;
    prev_data = cmd_data_o;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    int snap;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);

    // R1
    rreg(5'h12, v); chk("R1 status", 32'(v), 32'h0007);
    rreg(5'h06, v); chk("R1 wp", 32'(v), 32'h0);
    rreg(5'h0e, v); chk("R1 rp", 32'(v), 32'h0);
    rreg(5'h00, v); chk("R1 base", 32'(v), 32'h0);
    rreg(5'h04, v); chk("R1 len", 32'(v), 32'h0);
    chk("R1 no req", 32'(req_cnt), 32'd0);
    chk("R1 no valid", 32'(cmd_valid_o), 32'd0);

    // R2
    wreg(5'h02, 16'hffff); rreg(5'h02, v); chk("R2 base hi", 32'(v), 32'h007f);
    wreg(5'h0c, 16'hffff); rreg(5'h0c, v); chk("R2 ctrl", 32'(v), 32'h1ff0);
    wreg(5'h0c, 16'h1580); rreg(5'h0c, v); chk("R2 ctrl fields", 32'(v), 32'h1580);
    wreg(5'h04, 16'hffff); rreg(5'h04, v); chk("R2 len", 32'(v), 32'h007f);
    wreg(5'h0a, 16'hbeef); rreg(5'h0a, v); chk("R2 flip", 32'(v), 32'hbeef);
    wreg(5'h00, 16'h1000); rreg(5'h00, v); chk("R2 base lo", 32'(v), 32'h1000);
    wreg(5'h02, 16'h0002);
    wreg(5'h04, 16'h0000);
    m_base = 23'h021000; m_mask = 17'h003ff;

    // R5 R6 basic stream
    push_span(17'h0, 17'h8);
    wreg(5'h06, 16'h0008);
    wait_idle("R6 basic");
    rreg(5'h0e, v); chk("R7 rp after stream", 32'(v), 32'h0008);

    // R4 masked commit equals rd: no fetch
    snap = req_cnt;
    wreg(5'h06, 16'h0409);
    rreg(5'h06, v); chk("R4 masked wp", 32'(v), 32'h0008);
    repeat (10) @(negedge clk);
    chk("R5 equal ptrs no req", 32'(req_cnt), 32'(snap));

    // R4 odd low bit, with backpressure
    rdy_mode = 1;
    push_span(17'h8, 17'h12);
    wreg(5'h06, 16'h0013);
    rreg(5'h06, v); chk("R4 even wp", 32'(v), 32'h0012);
    wait_idle("R7 backpressure");
    rreg(5'h0e, v); chk("R7 rp after stall", 32'(v), 32'h0012);
    rdy_mode = 0;

    // R9 status
    eng2d_busy_i = 1'b1; rreg(5'h12, v); chk("R9 2d busy", 32'(v), 32'h0013);
    eng3d_busy_i = 1'b1; isp_busy_i = 1'b1;
    rreg(5'h12, v); chk("R9 all busy", 32'(v), 32'h0133);
    eng2d_busy_i = 1'b0; eng3d_busy_i = 1'b0; isp_busy_i = 1'b0;
    rreg(5'h12, v); chk("R9 idle", 32'(v), 32'h0007);

    // R10 read pointer commit ignored while busy
    rdy_mode = 2;
    push_span(17'h12, 17'h1a);
    wreg(5'h06, 16'h001a);
    for (int i = 0; i < 50 && !cmd_valid_o; i++) @(negedge clk);
    rreg(5'h12, v); chk("R9 reader busy", 32'(v), 32'h0000);
    wreg(5'h10, 16'h0000);
    wreg(5'h0e, 16'h0100);
    rreg(5'h0e, v); chk("R10 busy load ignored", 32'(v), 32'h0012);
    rdy_mode = 0;
    wait_idle("R10 stream continues");
    rreg(5'h0e, v); chk("R10 rp", 32'(v), 32'h001a);

    // R8 non power of two ring (3 KiB)
    wreg(5'h04, 16'h0002); m_mask = 17'h00bff;
    push_span(17'h1a, 17'hbfa);
    wreg(5'h06, 16'h0bfa);
    wait_idle("R8 long stream");
    push_span(17'hbfa, 17'h002);
    wreg(5'h06, 16'h0002);
    wait_idle("R8 wrap");
    rreg(5'h0e, v); chk("R8 rp wrapped", 32'(v), 32'h0002);

    // R3 staged high half
    wreg(5'h04, 16'h007f); m_mask = 17'h1ffff;
    snap = req_cnt;
    wreg(5'h08, 16'h0001);
    repeat (6) @(negedge clk);
    rreg(5'h08, v); chk("R3 wp hi staged", 32'(v), 32'h0000);
    chk("R3 no fetch on hi", 32'(req_cnt), 32'(snap));
    wreg(5'h08, 16'h0000);

    // R10 idle load across bit 16 and wrap
    push_span(17'h1fff0, 17'h00002);
    wreg(5'h10, 16'h0001);
    rreg(5'h10, v); chk("R3 rp hi staged", 32'(v), 32'h0000);
    wreg(5'h0e, 16'hfff0);
    wait_idle("R10 idle load");
    rreg(5'h10, v); chk("R8 rp hi after wrap", 32'(v), 32'h0000);
    rreg(5'h0e, v); chk("R8 rp lo after wrap", 32'(v), 32'h0002);

    // R3 high-half commit of both pointers
    rdy_mode = 2;
    push_span(17'h1ffe0, 17'h1ffe8);
    wreg(5'h08, 16'h0001);
    wreg(5'h10, 16'h0001);
    wreg(5'h0e, 16'hffe0);
    wreg(5'h06, 16'hffe8);
    rdy_mode = 0;
    wait_idle("R3 high commit");
    rreg(5'h08, v); chk("R3 wp hi", 32'(v), 32'h0001);
    rreg(5'h10, v); chk("R3 rp hi", 32'(v), 32'h0001);
    rreg(5'h0e, v); chk("R7 rp lo", 32'(v), 32'hffe8);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule